// File: doc/BRIEF.md
# Attribute Memory Control Register File

This block holds the small set of card-control registers that a host reaches through attribute memory. The registers sit at even byte addresses from 4000h and are selected when the active-low register-select input is low. Data moves one byte at a time on the low data lane. The host writes a byte with a one-cycle write strobe. Read data is presented one clock after the address.

The stored registers cover five functions: a soft reset bit, a power-down bit with a per-pair sleep selection, a socket and copy identifier, protection bits and a ready/busy configuration. A read-only status byte is assembled from those bits, the physical write-protect switch and the live per-device ready lines. The block also produces registered write-enable gates for common memory and for the information-structure region. Writes to the register region itself are never blocked by the switch.

Top module: `cmr_regfile`

## Requirements
- R1: While `rst` is high every writable register is cleared and `soft_rst` reads 1. On the first clock edge after `rst` falls, `soft_rst` drops to 0. All registers then read 00h, and the status byte at 4100h reads 01h when every device is ready.
- R2: Bit 7 of 4000h is the soft reset. While it is 1, `soft_rst` is high and every other writable register is held at 0, ignoring writes. Writing 0 ends the hold.
- R3: Bit 2 of 4002h is the power-down bit. 4118h bits [NPAIR-1:0] select pairs for sleep. `pair_pd[i]` equals sleep bit i AND power-down, valid one cycle after the write. 411Ah and unused sleep bits read 0.
- R4: 4006h holds the socket number in bits [3:0] and the copy number in bits [6:4]. Bit 7 reads 0.
- R5: 4104h holds three bits: bit 2 block-lock enable, bit 1 common-memory protect and bit 0 information-structure protect. All three read back, and bit 2 has no effect on any output.
- R6: `cm_wr_en` is 1 exactly when the switch is off and bit 1 of 4104h is 0. `cis_wr_en` is 1 exactly when the switch is off and bit 0 of 4104h is 0. Both update one cycle after their inputs.
- R7: 4100h is read-only. Its bits are:
  - bit 7: OR of the mask bits
  - bit 6: OR of the sleep bits
  - bit 5: soft reset
  - bit 4: common-memory protect
  - bit 3: power-down
  - bit 2: information-structure protect
  - bit 1: switch
  - bit 0: 1 when every device whose mask bit is 0 is ready

  Writes to 4100h are ignored.
- R8: The mask for device i is bit i%8 of 4120h (i<8) or 4122h (i>=8). The live ready line of device i reads in the same bit of 4130h/4132h. Unimplemented bits read 0.
- R9: 4140h holds the ready-acknowledge bit (bit 1, on `rb_ack`) and the high-performance mode bit (bit 0, on `rb_hp_mode`). Other bits read 0.
- R10: Odd addresses, undefined offsets and any access with `reg_sel_n` high read 00h and ignore writes.
- R11: Register writes take effect whatever the state of `wp_switch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel_n | input | 1 | Register-space select, active low |
| addr | input | AW | Byte address |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write byte |
| wp_switch | input | 1 | Physical write-protect switch, 1 = protect |
| dev_ready | input | 2*NPAIR | Live ready line per flash device |
| rd_data | output | 8 | Registered read byte |
| soft_rst | output | 1 | Soft reset state |
| pair_pd | output | NPAIR | Deep power-down per device pair |
| cm_wr_en | output | 1 | Common-memory write permitted |
| cis_wr_en | output | 1 | Information-structure write permitted |
| rb_ack | output | 1 | Ready-acknowledge bit |
| rb_hp_mode | output | 1 | Ready/busy high-performance mode bit |

## Verification
The bench targets the soft-reset hold. A design that let writes through during the hold would read back the socket byte written then, instead of 00h. It also checks the power-down AND, where a design ignoring the power-down bit would assert `pair_pd` as soon as a sleep bit is set. Masking is checked by driving a busy device and then masking it; a design that skipped the mask in the all-ready bit would keep status bit 0 low. With the switch on, the bench confirms that register writes still land while both write gates close. Odd, undefined and deselected accesses are exercised, where a loose decoder would alias into a real register.

// File: rtl/cmr_pkg.sv
`timescale 1ns/1ps
package cmr_pkg;
  // register byte offsets in attribute space
  localparam int unsigned OFS_COR  = 32'h4000;
  localparam int unsigned OFS_CCR  = 32'h4002;
  localparam int unsigned OFS_SCR  = 32'h4006;
  localparam int unsigned OFS_CSR  = 32'h4100;
  localparam int unsigned OFS_WPR  = 32'h4104;
  localparam int unsigned OFS_SLP0 = 32'h4118;
  localparam int unsigned OFS_SLP1 = 32'h411A;
  localparam int unsigned OFS_MSK0 = 32'h4120;
  localparam int unsigned OFS_MSK1 = 32'h4122;
  localparam int unsigned OFS_RDY0 = 32'h4130;
  localparam int unsigned OFS_RDY1 = 32'h4132;
  localparam int unsigned OFS_MODE = 32'h4140;

  typedef struct packed {
    logic       srst;
    logic       pwdn;
    logic [2:0] copy;
    logic [3:0] sock;
    logic       blken;
    logic       cmwp;
    logic       ciswp;
    logic       ack;
    logic       hp;
  } ctl_t;
endpackage

// File: rtl/cmr_store.sv
`timescale 1ns/1ps
module cmr_store
  import cmr_pkg::*;
#(
  parameter int AW    = 15,
  parameter int NPAIR = 6,
  parameter int NDEV  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wd,
  output ctl_t             ctl_q,
  output logic [NPAIR-1:0] sleep_q,
  output logic [NDEV-1:0]  mask_q
);
  logic tail_q;
  logic hold;

  assign hold = rst || ctl_q.srst;

  // soft reset bit: set by rst, auto-cleared on first free edge
  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q     <= 1'b1;
      ctl_q.srst <= 1'b1;
    end else if (tail_q) begin
      tail_q     <= 1'b0;
      ctl_q.srst <= 1'b0;
    end else if (wr && addr == AW'(OFS_COR)) begin
      ctl_q.srst <= wd[7];
    end
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      ctl_q.pwdn  <= 1'b0;
      ctl_q.copy  <= '0;
      ctl_q.sock  <= '0;
      ctl_q.blken <= 1'b0;
      ctl_q.cmwp  <= 1'b0;
      ctl_q.ciswp <= 1'b0;
      ctl_q.ack   <= 1'b0;
      ctl_q.hp    <= 1'b0;
    end else if (wr) begin
      case (addr)
        AW'(OFS_CCR): ctl_q.pwdn <= wd[2];
        AW'(OFS_SCR): begin
          ctl_q.copy <= wd[6:4];
          ctl_q.sock <= wd[3:0];
        end
        AW'(OFS_WPR): begin
          ctl_q.blken <= wd[2];
          ctl_q.cmwp  <= wd[1];
          ctl_q.ciswp <= wd[0];
        end
        AW'(OFS_MODE): begin
          ctl_q.ack <= wd[1];
          ctl_q.hp  <= wd[0];
        end
        default: ;
      endcase
    end
  end

  // one flop per sleep bit, byte lane picked from the bit index
  for (genvar i = 0; i < NPAIR; i++) begin : g_slp
    localparam int unsigned BOFS = OFS_SLP0 + 2 * (i / 8);
    always_ff @(posedge clk) begin
      if (hold)
        sleep_q[i] <= 1'b0;
      else if (wr && addr == AW'(BOFS))
        sleep_q[i] <= wd[i % 8];
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_msk
    localparam int unsigned BOFS = OFS_MSK0 + 2 * (i / 8);
    always_ff @(posedge clk) begin
      if (hold)
        mask_q[i] <= 1'b0;
      else if (wr && addr == AW'(BOFS))
        mask_q[i] <= wd[i % 8];
    end
  end
endmodule

// File: rtl/cmr_readmux.sv
`timescale 1ns/1ps
module cmr_readmux
  import cmr_pkg::*;
#(
  parameter int AW    = 15,
  parameter int NPAIR = 6,
  parameter int NDEV  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic [AW-1:0]    addr,
  input  ctl_t             ctl_q,
  input  logic [NPAIR-1:0] sleep_q,
  input  logic [NDEV-1:0]  mask_q,
  input  logic [NDEV-1:0]  dev_ready,
  input  logic             wp_sw,
  output logic [7:0]       rd_data
);
  localparam int PADW = 16;

  logic [PADW-1:0] slp_pad, msk_pad, rdy_pad;
  logic [7:0]      status;

  assign slp_pad = PADW'(sleep_q);
  assign msk_pad = PADW'(mask_q);
  assign rdy_pad = PADW'(dev_ready);

  always_comb begin
    status[7] = |mask_q;
    status[6] = |sleep_q;
    status[5] = ctl_q.srst;
    status[4] = ctl_q.cmwp;
    status[3] = ctl_q.pwdn;
    status[2] = ctl_q.ciswp;
    status[1] = wp_sw;
    status[0] = &(dev_ready | mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      rd_data <= '0;
    end else begin
      case (addr)
        AW'(OFS_COR):  rd_data <= {ctl_q.srst, 7'b0};
        AW'(OFS_CCR):  rd_data <= {5'b0, ctl_q.pwdn, 2'b0};
        AW'(OFS_SCR):  rd_data <= {1'b0, ctl_q.copy, ctl_q.sock};
        AW'(OFS_CSR):  rd_data <= status;
        AW'(OFS_WPR):  rd_data <= {5'b0, ctl_q.blken, ctl_q.cmwp, ctl_q.ciswp};
        AW'(OFS_SLP0): rd_data <= slp_pad[7:0];
        AW'(OFS_SLP1): rd_data <= slp_pad[15:8];
        AW'(OFS_MSK0): rd_data <= msk_pad[7:0];
        AW'(OFS_MSK1): rd_data <= msk_pad[15:8];
        AW'(OFS_RDY0): rd_data <= rdy_pad[7:0];
        AW'(OFS_RDY1): rd_data <= rdy_pad[15:8];
        AW'(OFS_MODE): rd_data <= {6'b0, ctl_q.ack, ctl_q.hp};
        default:       rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmr_gate.sv
`timescale 1ns/1ps
module cmr_gate
  import cmr_pkg::*;
#(
  parameter int NPAIR = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl_q,
  input  logic [NPAIR-1:0] sleep_q,
  input  logic             wp_sw,
  output logic             cm_wr_en,
  output logic             cis_wr_en,
  output logic [NPAIR-1:0] pair_pd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cm_wr_en  <= 1'b0;
      cis_wr_en <= 1'b0;
      pair_pd   <= '0;
    end else begin
      cm_wr_en  <= !wp_sw && !ctl_q.cmwp;
      cis_wr_en <= !wp_sw && !ctl_q.ciswp;
      pair_pd   <= sleep_q & {NPAIR{ctl_q.pwdn}};
    end
  end
endmodule

// File: rtl/cmr_regfile.sv
`timescale 1ns/1ps
module cmr_regfile
  import cmr_pkg::*;
#(
  parameter int AW    = 15,
  parameter int NPAIR = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel_n,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               wp_switch,
  input  logic [2*NPAIR-1:0] dev_ready,
  output logic [7:0]         rd_data,
  output logic               soft_rst,
  output logic [NPAIR-1:0]   pair_pd,
  output logic               cm_wr_en,
  output logic               cis_wr_en,
  output logic               rb_ack,
  output logic               rb_hp_mode
);
  localparam int NDEV = 2 * NPAIR;

  ctl_t             ctl_q;
  logic [NPAIR-1:0] sleep_q;
  logic [NDEV-1:0]  mask_q;
  logic             wr;

  // switch never gates the register region itself
  assign wr = wr_en && !reg_sel_n;

  cmr_store #(.AW(AW), .NPAIR(NPAIR), .NDEV(NDEV)) u_store (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wd(wr_data),
    .ctl_q(ctl_q), .sleep_q(sleep_q), .mask_q(mask_q)
  );

  cmr_readmux #(.AW(AW), .NPAIR(NPAIR), .NDEV(NDEV)) u_rd (
    .clk(clk), .rst(rst), .sel(!reg_sel_n), .addr(addr), .ctl_q(ctl_q),
    .sleep_q(sleep_q), .mask_q(mask_q), .dev_ready(dev_ready),
    .wp_sw(wp_switch), .rd_data(rd_data)
  );

  cmr_gate #(.NPAIR(NPAIR)) u_gate (
    .clk(clk), .rst(rst), .ctl_q(ctl_q), .sleep_q(sleep_q),
    .wp_sw(wp_switch), .cm_wr_en(cm_wr_en), .cis_wr_en(cis_wr_en),
    .pair_pd(pair_pd)
  );

  assign soft_rst   = ctl_q.srst;
  assign rb_ack     = ctl_q.ack;
  assign rb_hp_mode = ctl_q.hp;
endmodule

// File: rtl/cmr_regfile_chk.sv
`timescale 1ns/1ps
module cmr_regfile_chk #(
  parameter int NPAIR = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_sel_n,
  input logic             wp_switch,
  input logic             soft_rst,
  input logic [NPAIR-1:0] pair_pd,
  input logic             cm_wr_en,
  input logic             cis_wr_en,
  input logic [7:0]       rd_data,
  input logic             pwdn,
  input logic             cmwp,
  input logic [2:0]       prot
);
  // R1
  a_r1_reset_sets_soft: assert property (@(posedge clk) rst |=> soft_rst);
  // R2
  a_r2_hold_clears: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!pwdn && prot == 3'b000));
  // R3
  a_r3_pd_needs_pwdn: assert property (@(posedge clk) disable iff (rst)
    !pwdn |=> (pair_pd == '0));
  // R6
  a_r6_switch_blocks: assert property (@(posedge clk) disable iff (rst)
    wp_switch |=> (!cm_wr_en && !cis_wr_en));
  // R6
  a_r6_cm_open: assert property (@(posedge clk) disable iff (rst)
    (!wp_switch && !cmwp) |=> cm_wr_en);
  // R10
  a_r10_unsel_zero: assert property (@(posedge clk) disable iff (rst)
    reg_sel_n |=> (rd_data == 8'h00));
endmodule

bind cmr_regfile cmr_regfile_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst(rst), .reg_sel_n(reg_sel_n), .wp_switch(wp_switch),
  .soft_rst(soft_rst), .pair_pd(pair_pd), .cm_wr_en(cm_wr_en),
  .cis_wr_en(cis_wr_en), .rd_data(rd_data), .pwdn(ctl_q.pwdn),
  .cmwp(ctl_q.cmwp), .prot({ctl_q.blken, ctl_q.cmwp, ctl_q.ciswp})
);

// File: tb/cmr_regfile_bench.sv
`timescale 1ns/1ps
module cmr_regfile_bench;
  localparam int AW = 15;
  localparam int NPAIR = 6;
  localparam int NDEV = 2 * NPAIR;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_sel_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             wp_switch = 1'b0;
  logic [NDEV-1:0]  dev_ready = '1;
  logic [7:0]       rd_data;
  logic             soft_rst;
  logic [NPAIR-1:0] pair_pd;
  logic             cm_wr_en, cis_wr_en, rb_ack, rb_hp_mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmr_regfile #(.AW(AW), .NPAIR(NPAIR)) u_cmr_regfile (
    .clk(clk), .rst(rst), .reg_sel_n(reg_sel_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .wp_switch(wp_switch), .dev_ready(dev_ready),
    .rd_data(rd_data), .soft_rst(soft_rst), .pair_pd(pair_pd),
    .cm_wr_en(cm_wr_en), .cis_wr_en(cis_wr_en), .rb_ack(rb_ack),
    .rb_hp_mode(rb_hp_mode)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic nsel = 1'b0);
    @(negedge clk);
    reg_sel_n = nsel; addr = AW'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; reg_sel_n = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag,
                    input logic nsel = 1'b0);
    @(negedge clk);
    reg_sel_n = nsel; addr = AW'(a); wr_en = 1'b0;
    @(posedge clk); #1;
    chk(tag, {8'h00, rd_data}, {8'h00, exp});
    reg_sel_n = 1'b1;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 soft_rst during reset", 16'(soft_rst), 16'd1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 soft_rst after reset", 16'(soft_rst), 16'd0);
    rd(16'h4000, 8'h00, "R1 4000");
    rd(16'h4002, 8'h00, "R1 4002");
    rd(16'h4006, 8'h00, "R1 4006");
    rd(16'h4104, 8'h00, "R1 4104");
    rd(16'h4120, 8'h00, "R1 4120");
    rd(16'h4140, 8'h00, "R1 4140");
    rd(16'h4100, 8'h01, "R1 status");
  endtask

  task automatic t_soft();
    wr(16'h4002, 8'h04);
    wr(16'h4000, 8'h80);
    rd(16'h4000, 8'h80, "R2 set");
    chk("R2 soft_rst high", 16'(soft_rst), 16'd1);
    rd(16'h4002, 8'h00, "R2 pwdn cleared");
    wr(16'h4006, 8'h35);
    rd(16'h4006, 8'h00, "R2 write held off");
    wr(16'h4000, 8'h00);
    chk("R2 soft_rst low", 16'(soft_rst), 16'd0);
    wr(16'h4006, 8'h35);
    rd(16'h4006, 8'h35, "R2 write after release");
  endtask

  task automatic t_sockcopy();
    wr(16'h4006, 8'hFF);
    rd(16'h4006, 8'h7F, "R4 reserved bit7");
    wr(16'h4006, 8'h52);
    rd(16'h4006, 8'h52, "R4 copy5 sock2");
  endtask

  task automatic t_power();
    wr(16'h4118, 8'hFF);
    rd(16'h4118, 8'h3F, "R3 sleep width");
    rd(16'h411A, 8'h00, "R3 upper sleep");
    settle();
    chk("R3 no pd without pwdn", 16'(pair_pd), 16'h00);
    wr(16'h4002, 8'hFF);
    rd(16'h4002, 8'h04, "R3 pwdn readback");
    chk("R3 all pairs down", 16'(pair_pd), 16'h3F);
    wr(16'h4118, 8'h05);
    settle();
    chk("R3 selected pairs", 16'(pair_pd), 16'h05);
    wr(16'h4002, 8'h00);
    settle();
    chk("R3 pwdn off", 16'(pair_pd), 16'h00);
    wr(16'h4118, 8'h00);
  endtask

  task automatic t_protect();
    wr(16'h4104, 8'hFF);
    rd(16'h4104, 8'h07, "R5 readback");
    chk("R6 both closed", {cm_wr_en, cis_wr_en}, 2'b00);
    wr(16'h4104, 8'h04);
    settle();
    chk("R5 blken no effect", {cm_wr_en, cis_wr_en}, 2'b11);
    wr(16'h4104, 8'h02);
    settle();
    chk("R6 cm protect", {cm_wr_en, cis_wr_en}, 2'b01);
    wr(16'h4104, 8'h01);
    settle();
    chk("R6 cis protect", {cm_wr_en, cis_wr_en}, 2'b10);
    wr(16'h4104, 8'h00);
    @(negedge clk); wp_switch = 1'b1;
    settle();
    chk("R6 switch closes", {cm_wr_en, cis_wr_en}, 2'b00);
    wr(16'h4006, 8'h12);
    rd(16'h4006, 8'h12, "R11 write under switch");
    @(negedge clk); wp_switch = 1'b0;
    settle();
    chk("R6 switch off opens", {cm_wr_en, cis_wr_en}, 2'b11);
  endtask

  task automatic t_status();
    wr(16'h4122, 8'h02);
    wr(16'h4118, 8'h01);
    wr(16'h4002, 8'h04);
    wr(16'h4104, 8'h03);
    @(negedge clk); wp_switch = 1'b1; dev_ready = 12'hDFF;
    rd(16'h4100, 8'hDF, "R7 composed");
    wr(16'h4100, 8'h00);
    rd(16'h4100, 8'hDF, "R7 write ignored");
    wr(16'h4122, 8'h00);
    rd(16'h4100, 8'h5E, "R7 unmasked busy");
    @(negedge clk); wp_switch = 1'b0; dev_ready = '1;
    wr(16'h4118, 8'h00);
    wr(16'h4002, 8'h00);
    wr(16'h4104, 8'h00);
  endtask

  task automatic t_ready();
    @(negedge clk); dev_ready = 12'hA5C;
    rd(16'h4130, 8'h5C, "R8 ready low");
    rd(16'h4132, 8'h0A, "R8 ready high");
    wr(16'h4120, 8'hFF);
    wr(16'h4122, 8'hFF);
    rd(16'h4120, 8'hFF, "R8 mask low");
    rd(16'h4122, 8'h0F, "R8 mask high");
    rd(16'h4100, 8'h81, "R8 all masked ready");
    wr(16'h4120, 8'h00);
    wr(16'h4122, 8'h00);
    @(negedge clk); dev_ready = '1;
  endtask

  task automatic t_mode();
    wr(16'h4140, 8'hFF);
    rd(16'h4140, 8'h03, "R9 readback");
    chk("R9 pins", {rb_ack, rb_hp_mode}, 2'b11);
    wr(16'h4140, 8'h01);
    chk("R9 ack cleared", {rb_ack, rb_hp_mode}, 2'b01);
  endtask

  task automatic t_undef();
    wr(16'h4001, 8'h80);
    chk("R10 odd write ignored", 16'(soft_rst), 16'd0);
    rd(16'h4001, 8'h00, "R10 odd read");
    wr(16'h4008, 8'hFF);
    rd(16'h4008, 8'h00, "R10 undefined");
    wr(16'h4006, 8'h77, 1'b1);
    rd(16'h4006, 8'h00, "R10 deselected read", 1'b1);
    rd(16'h4006, 8'h52, "R10 deselected write ignored");
  endtask

  initial begin
    t_reset();
    t_soft();
    t_sockcopy();
    t_power();
    wr(16'h4006, 8'h52);
    t_protect();
    wr(16'h4006, 8'h52);
    t_status();
    t_ready();
    t_mode();
    t_undef();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule